// File: doc/BRIEF.md
# Prescaled Down-Counting Interval Timer

This block is a small timer peripheral that sits on a plain 32-bit register bus. Software writes a 16-bit start value, picks a clock divide ratio and a counting mode, and sets an enable bit. The counter then steps down by one on every divided tick. When a tick finds the counter at zero, an underflow happens: in reload mode the counter is filled again from the stored start value, and in wrap mode it rolls over to all ones.

Each underflow raises a level interrupt line. The line stays high until software writes any value to the acknowledge register. The live count can be read back at any time. This supports two uses: a periodic system tick, and a one-shot busy-wait delay that polls the count.

Top module: `interval_timer`

## Requirements
- R1: After synchronous reset, the start value, the count, the control register and the interrupt line are all zero.
- R2: The start-value register is at word offset 0x0 and holds bits 15:0 of the write data; bits 31:16 read back as zero. A write to it loads the counter with the same value at the same clock edge, whether or not the timer is enabled.
- R3: The count register at offset 0x4 reads the live counter, zero-extended to 32 bits. Writes to it are ignored. The acknowledge register at offset 0xC reads back as zero.
- R4: The control register is at offset 0x8. Bit 7 is enable, bit 6 selects reload mode (1) or wrap mode (0), and bits 3:2 select the divide ratio. All other bits read back as zero.
- R5: While enable is 0, the counter holds its value.
- R6: Divide code 00 ticks on every enabled cycle, code 01 on every 16th and codes 10 and 11 on every 256th. The divider restarts from zero each time enable goes from 0 to 1, so the first tick comes a full divide period after enabling.
- R7: In reload mode, a tick at count 0 loads the counter from the start-value register.
- R8: In wrap mode, a tick at count 0 sets the counter to 0xFFFF.
- R9: Every underflow sets the interrupt line, and the line stays high until it is acknowledged.
- R10: Any write to offset 0xC clears the interrupt line, whatever the data. If an underflow happens at the same edge, the line stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe; the write takes effect at the rising edge |
| bus_addr | input | 4 | Byte offset; bits 3:2 select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the register at bus_addr (combinational) |
| irq | output | 1 | Level interrupt, high from an underflow until it is acknowledged |

## Verification
Random runs vary the start value, the mode, the divide code and the wait length. Each result is compared with a tick-by-tick model. The counts therefore show whether the divide ratio is right, whether an underflow reloads or wraps, and whether the interrupt is raised. Directed cases cover the exact tick edge at divide-by-16 and divide-by-256, and the divider restart on re-enable. They also cover the wrap to 0xFFFF, a start-value write while counting, the hold while disabled, and the read-only and zero-reading register bits. A final case makes an acknowledge coincide with an underflow, which separates "set wins" from "clear wins".

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CNT_W  = 16;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;
    localparam int PS_W   = 8;

    typedef enum logic [1:0] {
        REG_START = 2'd0,
        REG_COUNT = 2'd1,
        REG_CTRL  = 2'd2,
        REG_ACK   = 2'd3
    } tmr_reg_e;

    typedef struct packed {
        logic       run;
        logic       reload;
        logic [1:0] div_sel;
    } tmr_ctrl_t;

    // terminal value of the divider for a divide code
    function automatic logic [PS_W-1:0] div_last(input logic [1:0] code);
        logic [PS_W-1:0] r;
        case (code)
            2'b00:   r = '0;
            2'b01:   r = PS_W'(15);
            default: r = PS_W'(255);
        endcase
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_image(input tmr_ctrl_t c);
        logic [DATA_W-1:0] r;
        r = '0;
        r[7]   = c.run;
        r[6]   = c.reload;
        r[3:2] = c.div_sel;
        return r;
    endfunction

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [CW-1:0] count,
    output tmr_ctrl_t     ctrl,
    output logic [CW-1:0] start_val,
    output logic          start_wr,
    output logic [CW-1:0] start_data,
    output logic          ack_wr
);

    tmr_reg_e sel;
    assign sel        = tmr_reg_e'(bus_addr[3:2]);
    assign start_wr   = bus_wr && (sel == REG_START);
    assign ack_wr     = bus_wr && (sel == REG_ACK);
    assign start_data = bus_wdata[CW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            start_val <= '0;
        end else if (bus_wr) begin
            if (sel == REG_CTRL) begin
                ctrl.run     <= bus_wdata[7];
                ctrl.reload  <= bus_wdata[6];
                ctrl.div_sel <= bus_wdata[3:2];
            end
            if (sel == REG_START)
                start_val <= bus_wdata[CW-1:0];
        end
    end

    always_comb begin
        case (sel)
            REG_START: bus_rdata = DW'(start_val);
            REG_COUNT: bus_rdata = DW'(count);
            REG_CTRL:  bus_rdata = ctrl_image(ctrl);
            default:   bus_rdata = '0;
        endcase
    end

    // R4
    always_comb begin
        if (!rst && sel == REG_CTRL)
            ctrl_unused_zero_chk: assert ((bus_rdata & ~DW'(32'hCC)) == '0);
    end

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int PW = PS_W
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [1:0] div_sel,
    output logic       tick
);

    logic [PW-1:0] phase;
    logic [PW-1:0] last;

    assign last = div_last(div_sel);
    assign tick = run && (phase >= last);

    always_ff @(posedge clk) begin
        if (rst || !run)
            phase <= '0;
        else if (phase >= last)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

    // R6
    phase_restart_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (phase == '0));

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          reload,
    input  logic          run,
    input  logic [CW-1:0] start_val,
    input  logic          start_wr,
    input  logic [CW-1:0] start_data,
    input  logic          ack_wr,
    output logic [CW-1:0] count,
    output logic          irq
);

    logic underflow;
    assign underflow = tick && !start_wr && (count == '0);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (start_wr)
            count <= start_data;
        else if (tick) begin
            if (count == '0)
                count <= reload ? start_val : '1;
            else
                count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            irq <= 1'b0;
        else if (underflow)
            irq <= 1'b1;
        else if (ack_wr)
            irq <= 1'b0;
    end

    // R5
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !start_wr) |=> $stable(count));

    // R7
    reload_value_chk: assert property (@(posedge clk) disable iff (rst)
        (underflow && reload) |=> (count == $past(start_val)));

    // R8
    wrap_value_chk: assert property (@(posedge clk) disable iff (rst)
        (underflow && !reload) |=> (count == '1));

    // R9
    irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
        underflow |=> irq);

    // R10
    irq_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_wr && !underflow) |=> !irq);

endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    tmr_ctrl_t         ctrl;
    logic [CNT_W-1:0]  start_val;
    logic              start_wr;
    logic [CNT_W-1:0]  start_data;
    logic              ack_wr;
    logic [CNT_W-1:0]  count;
    logic              tick;

    tmr_regs #(.DW(DATA_W), .AW(ADDR_W), .CW(CNT_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .count      (count),
        .ctrl       (ctrl),
        .start_val  (start_val),
        .start_wr   (start_wr),
        .start_data (start_data),
        .ack_wr     (ack_wr)
    );

    tmr_prescaler #(.PW(PS_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl.run),
        .div_sel (ctrl.div_sel),
        .tick    (tick)
    );

    tmr_counter #(.CW(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .reload     (ctrl.reload),
        .run        (ctrl.run),
        .start_val  (start_val),
        .start_wr   (start_wr),
        .start_data (start_data),
        .ack_wr     (ack_wr),
        .count      (count),
        .irq        (irq)
    );

endmodule

// File: tb/interval_timer_test.sv
module interval_timer_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] A_START = 4'h0;
    localparam logic [3:0] A_COUNT = 4'h4;
    localparam logic [3:0] A_CTRL  = 4'h8;
    localparam logic [3:0] A_ACK   = 4'hC;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    interval_timer uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // tick-by-tick expectation built from R7/R8
    function automatic logic [15:0] model(input logic [15:0] sv, input int ticks,
                                          input bit per, output bit fired);
        logic [15:0] v;
        v = sv;
        fired = 0;
        for (int i = 0; i < ticks; i++) begin
            if (v == 16'h0) begin
                v = per ? sv : 16'hFFFF;
                fired = 1;
            end else
                v = v - 16'h1;
        end
        return v;
    endfunction

    function automatic int div_of(input logic [1:0] code);
        return (code == 2'b00) ? 1 : (code == 2'b01) ? 16 : 256;
    endfunction

    function automatic logic [31:0] ctl(input bit en, input bit per, input logic [1:0] code);
        return {24'h0, en, per, 2'b00, code, 2'b00};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a falling edge; write lands at the next rising edge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            finish_run();
        end
    end

    initial begin
        logic [31:0] d;
        bit fired;
        logic [15:0] e;
        void'($urandom(32'd20240611));
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(1);

        // R1 reset state
        rd(A_START, d); chk("R1 start", d, 0);
        rd(A_COUNT, d); chk("R1 count", d, 0);
        rd(A_CTRL, d);  chk("R1 ctrl", d, 0);
        chk("R1 irq", {31'h0, irq}, 0);

        // R4 unused control bits read zero
        wr(A_CTRL, 32'hFFFF_FF3F);
        rd(A_CTRL, d); chk("R4 unused bits", d, 32'h0000_000C);
        wr(A_CTRL, 0);

        // R2 upper bits zero, load while disabled
        wr(A_START, 32'hABCD_1234);
        rd(A_START, d); chk("R2 start readback", d, 32'h0000_1234);
        rd(A_COUNT, d); chk("R2 load while stopped", d, 32'h0000_1234);

        // R3 count read-only, ack reads zero
        wr(A_COUNT, 32'h0000_0055);
        rd(A_COUNT, d); chk("R3 count write ignored", d, 32'h0000_1234);
        rd(A_ACK, d);   chk("R3 ack reads zero", d, 0);

        // R5 hold while disabled
        wait_cyc(10);
        rd(A_COUNT, d); chk("R5 hold", d, 32'h0000_1234);

        // R8 wrap mode, divide by 1
        wr(A_START, 2);
        wr(A_CTRL, ctl(1, 0, 2'b00));
        wait_cyc(2);
        rd(A_COUNT, d); chk("R8 before wrap", d, 0);
        chk("R9 no irq yet", {31'h0, irq}, 0);
        wait_cyc(1);
        rd(A_COUNT, d); chk("R8 wrap", d, 32'h0000_FFFF);
        chk("R9 irq set", {31'h0, irq}, 1);
        wait_cyc(5);
        chk("R9 irq held", {31'h0, irq}, 1);
        wr(A_ACK, 32'h1234_5678);
        chk("R10 ack clears", {31'h0, irq}, 0);

        // R6 divide by 16 and restart on re-enable
        wr(A_CTRL, 0);
        wr(A_START, 5);
        wr(A_CTRL, ctl(1, 1, 2'b01));
        wait_cyc(15);
        rd(A_COUNT, d); chk("R6 div16 before tick", d, 5);
        wait_cyc(1);
        rd(A_COUNT, d); chk("R6 div16 tick", d, 4);
        wait_cyc(10);
        wr(A_CTRL, 0);
        wr(A_CTRL, ctl(1, 1, 2'b01));
        wait_cyc(15);
        rd(A_COUNT, d); chk("R6 divider restart", d, 4);
        wait_cyc(1);
        rd(A_COUNT, d); chk("R6 divider restart tick", d, 3);

        // R6 divide by 256 (code 11)
        wr(A_CTRL, 0);
        wr(A_START, 1);
        wr(A_CTRL, ctl(1, 1, 2'b11));
        wait_cyc(255);
        rd(A_COUNT, d); chk("R6 div256 before tick", d, 1);
        wait_cyc(1);
        rd(A_COUNT, d); chk("R6 div256 tick", d, 0);

        // R2 load while running, R7 reload
        wr(A_CTRL, 0);
        wr(A_START, 3);
        wr(A_CTRL, ctl(1, 1, 2'b00));
        wait_cyc(4);
        rd(A_COUNT, d); chk("R7 reload", d, 3);
        wr(A_ACK, 0);
        wr(A_START, 100);
        rd(A_COUNT, d); chk("R2 load while running", d, 100);
        wait_cyc(5);
        rd(A_COUNT, d); chk("R2 count after load", d, 95);

        // R10 ack coinciding with underflow
        wr(A_CTRL, 0);
        wr(A_ACK, 0);
        wr(A_START, 3);
        wr(A_CTRL, ctl(1, 1, 2'b00));
        wait_cyc(7);
        wr(A_ACK, 0);
        chk("R10 underflow wins", {31'h0, irq}, 1);
        wr(A_ACK, 0);
        chk("R10 later ack clears", {31'h0, irq}, 0);
        rd(A_COUNT, d); chk("R7 count after reload", d, 2);

        // random runs against the model (R6, R7, R8, R9)
        for (int it = 0; it < 30; it++) begin
            logic [15:0] sv;
            logic [1:0]  code;
            bit per;
            int n;
            sv   = 16'($urandom_range(0, 255));
            code = 2'($urandom_range(0, 3));
            per  = 1'($urandom_range(0, 1));
            n    = (code >= 2) ? $urandom_range(1, 1200) : $urandom_range(1, 600);
            wr(A_CTRL, 0);
            wr(A_ACK, 0);
            wr(A_START, {16'h0, sv});
            wr(A_CTRL, ctl(1, per, code));
            wait_cyc(n);
            e = model(sv, n / div_of(code), per, fired);
            rd(A_COUNT, d); chk("R6/R7/R8 random count", d, {16'h0, e});
            chk("R9 random irq", {31'h0, irq}, {31'h0, fired});
        end

        done = 1;
        finish_run();
    end

endmodule